// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Core

This block is a cycle-level, synthesizable model of a pipelined synchronous burst SRAM built around a small internal array. On every rising clock edge it samples three chip enables, two address strobes, a burst-advance input, the write controls and a sleep input. From these it decides whether the cycle deselects the device, loads an external address to start a burst, steps to the next burst address, or stays on the current one. It then reads or writes that location.

The processor strobe (`pstb_n`) and the controller strobe (`cstb_n`) follow different rules. A processor-strobe start is always a read, and it is honoured only while chip enable 1 is low. A controller-strobe start can be a read or a write, depending on the combined write signal. Once a burst is running, continue and suspend cycles use no chip-enable check at all.

The data bus is modelled as split input and output lanes with a drive enable. Read data is registered, and the drive enable is gated without a clock by the output-enable and sleep inputs. Each data lane carries eight data bits and one parity bit. Bursts wrap within an aligned group of four words, in either linear or interleaved order.

Top module: `sbsram_core`

## Requirements
- R1: While `sleep` is high, `dq_oe` is low at once, without waiting for a clock edge. Every other input is ignored: no write occurs and the burst address does not change.
- R2: A cycle is a deselect, and its data slot is never driven, in two cases. The first is `cstb_n` low with `ce1_n` high, whatever `pstb_n` does. The second is a start by either strobe while `ce2` is low or `ce3_n` is high.
- R3: With `ce1_n` high, `pstb_n` has no effect. With `cstb_n` high, the cycle acts as a continue (`adv_n` low) or a suspend (`adv_n` high).
- R4: `pstb_n` low with the chip selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0) loads `addr` and starts a read burst, even when `gw_n` or the byte writes are asserted.
- R5: `pstb_n` high, `cstb_n` low and the chip selected loads `addr`. The cycle is a write when the combined write signal is low and a read otherwise.
- R6: With both strobes high (or `pstb_n` low and `ce1_n` high), `adv_n` low moves to the next burst address and `adv_n` high keeps the current one. The cycle reads or writes according to the combined write signal.
- R7: The combined write signal is low when `gw_n` is low, or when `bwe_n` is low and at least one `bw_n` bit is low. With `bwe_n` high and `gw_n` high, the cycle is a read.
- R8: `gw_n` low writes every lane. Otherwise, with `bwe_n` low, each lane whose `bw_n` bit is low is written. Lane l (l=0 is lane A) occupies bits [9l+8:9l] of `dq_i`/`dq_o`, and bit 9l+8 is its parity bit.
- R9: `dq_oe` is high only when `oe_n` is low, `sleep` is low and the current data slot belongs to a selected read cycle. `oe_n` acts without a clock, and the slot that follows a write or deselect cycle is never driven.
- R10: The burst counter wraps within the aligned group of four words on `addr[1:0]`. With `burst_lin`=1 the offset is (start+n) mod 4; with `burst_lin`=0 it is start XOR n.
- R11: The data of a read cycle sampled at edge k appears on `dq_o` after edge k+1 and stays there until edge k+2.
- R12: While `rst` is high at a clock edge, the read pipeline is cleared and the burst state returns to address 0, so `dq_oe` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Sleep: floats the bus and freezes the core |
| ce1_n | input | 1 | Chip enable 1, active low; gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | AW | External word address |
| dq_i | input | LANES*LANE_W | Write data lanes with parity |
| dq_o | output | LANES*LANE_W | Read data lanes with parity |
| dq_oe | output | 1 | Drive enable for `dq_o` |

## Verification
The hardest situation to reach is a burst that is suspended part-way, wraps across its group of four, and mixes byte-masked writes with reads of the same words. Only that combination shows whether the counter, the lane masks and the read pipeline agree. The directed stimulus starts linear and interleaved bursts at non-zero offsets, holds them between steps, writes lane-masked patterns through continue cycles, and reads everything back with processor-strobe starts. A long random run then mixes sleep, deselects, masked strobes and output-enable changes. After each clock, the bench compares the result against a behavioural memory model.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_DESEL = 3'd1,
        OP_LOAD  = 3'd2,
        OP_NEXT  = 3'd3,
        OP_HOLD  = 3'd4
    } op_e;

    localparam int unsigned GRP_W = 2;

    function automatic logic [GRP_W-1:0] burst_ofs(
        input logic [GRP_W-1:0] start,
        input logic [GRP_W-1:0] step,
        input logic             lin
    );
        return lin ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             sleep,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output op_e              op,
    output logic             wr,
    output logic [LANES-1:0] lane_we
);
    logic             selected;
    logic             wr_req;
    logic [LANES-1:0] lane_sel;

    always_comb begin
        selected = !ce1_n && ce2 && !ce3_n;
        wr_req   = !gw_n || (!bwe_n && !(&bw_n));
        if (!gw_n)       lane_sel = '1;
        else if (!bwe_n) lane_sel = ~bw_n;
        else             lane_sel = '0;

        if (sleep) begin
            op = OP_IDLE;
            wr = 1'b0;
        end else if (!pstb_n && !ce1_n) begin
            op = selected ? OP_LOAD : OP_DESEL;
            wr = 1'b0;
        end else if (!cstb_n) begin
            op = selected ? OP_LOAD : OP_DESEL;
            wr = selected && wr_req;
        end else begin
            op = adv_n ? OP_HOLD : OP_NEXT;
            wr = wr_req;
        end
        lane_we = wr ? lane_sel : '0;
    end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic             lin,
    input  logic [AW-1:0]    ext_addr,
    output logic [AW-1:0]    cur_addr,
    output logic [AW-1:0]    base_q,
    output logic [GRP_W-1:0] cnt_q
);
    logic [AW-1:0]    base_d;
    logic [GRP_W-1:0] cnt_d;

    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        unique case (op)
            OP_LOAD: begin
                base_d = ext_addr;
                cnt_d  = '0;
            end
            OP_NEXT: cnt_d = cnt_q + 1'b1;
            default: ;
        endcase
        cur_addr = {base_d[AW-1:GRP_W], burst_ofs(base_d[GRP_W-1:0], cnt_d, lin)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int unsigned AW     = 6,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    rd_req,
    output logic [LANES*LANE_W-1:0] dout_q,
    output logic                    vld_q
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned DW    = LANES * LANE_W;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_addr_q;
    logic          rd_pend_q;

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (lane_we[l]) mem[addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
        end
        rd_addr_q <= addr;
        dout_q    <= mem[rd_addr_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q <= 1'b0;
            vld_q     <= 1'b0;
        end else begin
            rd_pend_q <= rd_req;
            vld_q     <= rd_pend_q;
        end
    end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int unsigned AW     = 6,
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    burst_lin,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);
    op_e              op;
    logic             wr;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    base_q;
    logic [GRP_W-1:0] cnt_q;
    logic             rd_req;
    logic             vld_q;

    sbsram_decode #(.LANES(LANES)) u_dec (
        .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .op(op), .wr(wr), .lane_we(lane_we)
    );

    sbsram_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst(rst), .op(op), .lin(burst_lin), .ext_addr(addr),
        .cur_addr(cur_addr), .base_q(base_q), .cnt_q(cnt_q)
    );

    assign rd_req = !wr && (op == OP_LOAD || op == OP_NEXT || op == OP_HOLD);

    sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .rst(rst), .addr(cur_addr), .lane_we(lane_we),
        .din(dq_i), .rd_req(rd_req), .dout_q(dq_o), .vld_q(vld_q)
    );

    assign dq_oe = vld_q && !oe_n && !sleep;
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          sleep,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          pstb_n,
    input logic          cstb_n,
    input logic          adv_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic          vld_q,
    input logic [AW-1:0] base_q,
    input logic [1:0]    cnt_q
);
    // R1: sleep floats the bus
    a_r1_sleep_floats: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe);

    // R9: output enable high never drives
    a_r9_oe_gates_bus: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    // R2: controller strobe while deselected leaves its slot empty
    a_r2_desel_no_data: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !cstb_n && (ce1_n || !ce2 || ce3_n)) |-> ##2 !vld_q);

    // R4: processor strobe start while selected is a read
    a_r4_pstb_reads: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !pstb_n && !ce1_n && ce2 && !ce3_n) |-> ##2 vld_q);

    // R6: suspend keeps the burst state
    a_r6_hold_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (!sleep && cstb_n && (pstb_n || ce1_n) && adv_n)
            |=> ($stable(base_q) && $stable(cnt_q)));
endmodule

bind sbsram_core sbsram_core_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
    .oe_n(oe_n), .dq_oe(dq_oe), .vld_q(vld_q), .base_q(base_q), .cnt_q(cnt_q)
);

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;
    localparam int AW = 6, LANES = 2, LW = 9, DW = 18, DEPTH = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, sleep = 1'b0, ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic oe_n = 1'b0, burst_lin = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0, dq_o;
    logic dq_oe;

    sbsram_core #(.AW(AW), .LANES(LANES), .LANE_W(LW)) dut_i (
        .clk(clk), .rst(rst), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .burst_lin(burst_lin), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    int vectors = 0, misses = 0;
    string tag = "R12 reset";

    // behavioural reference
    logic [DW-1:0] mem_m [DEPTH];
    int m_base = 0, m_cnt = 0, p_addr = 0;
    bit m_vld = 0, p_rd = 0;
    logic [DW-1:0] m_dout = '0;

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 2731) ^ 'h15a5a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_vld = 0; p_rd = 0; m_base = 0; m_cnt = 0;
        end else begin
            bit sel, wsig, iswr;
            int kind, ofs, a;
            m_vld = p_rd;
            if (p_rd) m_dout = mem_m[p_addr];
            p_rd = 0;
            if (!sleep) begin
                sel  = (ce1_n == 0) && (ce2 == 1) && (ce3_n == 0);
                wsig = (gw_n == 0) || (bwe_n == 0 && bw_n != '1);
                if (pstb_n == 0 && ce1_n == 0) begin kind = sel ? 1 : 0; iswr = 0; end
                else if (cstb_n == 0)          begin kind = sel ? 1 : 0; iswr = wsig; end
                else                           begin kind = adv_n ? 3 : 2; iswr = wsig; end
                if (kind == 1) begin m_base = int'(addr); m_cnt = 0; end
                if (kind == 2) m_cnt = (m_cnt + 1) % 4;
                if (kind != 0) begin
                    ofs = burst_lin ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
                    a = (m_base / 4) * 4 + ofs;
                    if (iswr) begin
                        for (int l = 0; l < LANES; l++)
                            if (gw_n == 0 || bw_n[l] == 0)
                                mem_m[a][l*LW +: LW] = dq_i[l*LW +: LW];
                    end else begin
                        p_rd = 1; p_addr = a;
                    end
                end
            end
        end
    end

    // every-clock comparison
    always @(negedge clk) begin
        bit exp_oe;
        exp_oe = m_vld && !oe_n && !sleep;
        vectors++;
        if (dq_oe !== exp_oe) begin
            misses++;
            $display("FAIL %s: dq_oe act=%b exp=%b at %0t", tag, dq_oe, exp_oe, $time);
        end else if (exp_oe && dq_o !== m_dout) begin
            misses++;
            $display("FAIL %s: dq_o act=%h exp=%h at %0t", tag, dq_o, m_dout, $time);
        end
    end

    task automatic chk(string t, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic go();
        @(negedge clk);
        #1;
    endtask

    task automatic cmd(logic p, logic c, logic a, logic g, logic be,
                       logic [LANES-1:0] b, int ad, logic [DW-1:0] d);
        pstb_n = p; cstb_n = c; adv_n = a; gw_n = g; bwe_n = be; bw_n = b;
        addr = AW'(ad); dq_i = d;
    endtask

    task automatic sel_on();
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic hold_rd();
        cmd(1, 1, 1, 1, 1, '1, 0, '0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: act=running exp=finished");
        summary();
    end

    initial begin
        hold_rd();
        repeat (3) go();
        chk("R12 no drive in reset", DW'(dq_oe), '0);
        rst = 0;

        tag = "R5 R8 preload write";
        for (int a = 0; a < DEPTH; a++) begin
            cmd(1, 0, 1, 0, 1, '1, a, pat(a)); go();
        end
        hold_rd(); go();

        tag = "R4 R11 pstb read with writes asserted";
        cmd(0, 1, 1, 0, 0, '0, 5, '1); go();
        hold_rd(); go();
        chk("R4 R11 pstb read data", dq_o, pat(5));
        chk("R11 read drives", DW'(dq_oe), DW'(1));

        tag = "R5 cstb read";
        cmd(1, 0, 1, 1, 1, '1, 9, '0); go();
        hold_rd(); go();
        chk("R5 cstb read data", dq_o, pat(9));

        tag = "R10 R6 linear burst";
        cmd(1, 0, 1, 1, 1, '1, 6, '0); go();
        cmd(1, 1, 0, 1, 1, '1, 0, '0); go(); chk("R10 linear 0", dq_o, pat(6));
        go(); chk("R10 linear 1", dq_o, pat(7));
        go(); chk("R10 linear wrap", dq_o, pat(4));
        hold_rd(); go(); chk("R10 linear 3", dq_o, pat(5));
        go(); chk("R6 suspend", dq_o, pat(5));

        tag = "R10 interleaved burst";
        burst_lin = 0;
        cmd(1, 0, 1, 1, 1, '1, 13, '0); go();
        cmd(1, 1, 0, 1, 1, '1, 0, '0); go(); chk("R10 inter 0", dq_o, pat(13));
        go(); chk("R10 inter 1", dq_o, pat(12));
        go(); chk("R10 inter 2", dq_o, pat(15));
        hold_rd(); go(); chk("R10 inter 3", dq_o, pat(14));
        burst_lin = 1;

        tag = "R8 R7 byte writes";
        cmd(1, 0, 1, 0, 1, '1, 16, '1); go();
        cmd(1, 1, 0, 1, 0, 2'b10, 0, '0); go();
        cmd(1, 1, 0, 1, 0, 2'b01, 0, '0); go();
        cmd(1, 1, 0, 1, 0, 2'b00, 0, 18'h2aaaa); go();
        cmd(1, 1, 1, 1, 1, 2'b00, 0, '0); go();
        go();
        chk("R7 bwe high is read", {dq_o[DW-1:1], dq_oe}, {18'h2aaaa >> 1, 1'b1});
        for (int a = 16; a < 20; a++) begin
            logic [DW-1:0] e;
            cmd(0, 1, 1, 1, 1, '1, a, '0); go();
            hold_rd(); go();
            case (a)
                16: e = '1;
                17: e = {pat(17)[17:9], 9'h0};
                18: e = {9'h0, pat(18)[8:0]};
                default: e = 18'h2aaaa;
            endcase
            chk("R8 lane mask readback", dq_o, e);
        end

        tag = "R6 write after pstb start";
        cmd(0, 1, 1, 1, 1, '1, 20, '0); go();
        cmd(1, 1, 1, 0, 1, '1, 0, 18'h12345); go();
        cmd(0, 1, 1, 1, 1, '1, 20, '0); go();
        hold_rd(); go();
        chk("R6 continue write", dq_o, 18'h12345);

        tag = "R2 deselect";
        ce1_n = 1; cmd(0, 0, 1, 1, 1, '1, 3, '0); go();
        sel_on(); hold_rd(); go(); chk("R2 cstb with ce1 high", DW'(dq_oe), '0);
        ce2 = 0; cmd(0, 1, 1, 1, 1, '1, 3, '0); go();
        sel_on(); hold_rd(); go(); chk("R2 pstb with ce2 low", DW'(dq_oe), '0);
        ce3_n = 1; cmd(1, 0, 1, 1, 1, '1, 3, '0); go();
        sel_on(); hold_rd(); go(); chk("R2 cstb with ce3 high", DW'(dq_oe), '0);

        tag = "R3 ce1 masks pstb";
        cmd(1, 0, 1, 1, 1, '1, 24, '0); go();
        ce1_n = 1; cmd(0, 1, 0, 1, 1, '1, 40, '0); go();
        chk("R3 start data", dq_o, pat(24));
        cmd(0, 1, 1, 1, 1, '1, 40, '0); go();
        chk("R3 pstb acts as continue", dq_o, pat(25));
        sel_on();

        tag = "R9 oe gating";
        hold_rd(); go(); go();
        oe_n = 1; #1; chk("R9 oe high floats now", DW'(dq_oe), '0);
        oe_n = 0; #1; chk("R9 oe low drives now", DW'(dq_oe), DW'(1));
        cmd(1, 0, 1, 0, 1, '1, 30, 18'h0f0f0); go();
        hold_rd(); go();
        chk("R9 write slot not driven", DW'(dq_oe), '0);

        tag = "R1 sleep";
        go(); go();
        sleep = 1; #1; chk("R1 sleep floats now", DW'(dq_oe), '0);
        cmd(1, 0, 1, 0, 1, '1, 40, '0); go(); go();
        sleep = 0; cmd(0, 1, 1, 1, 1, '1, 40, '0); go();
        hold_rd(); go();
        chk("R1 write ignored in sleep", dq_o, pat(40));

        tag = "random mix";
        for (int i = 0; i < 3000; i++) begin
            sleep  = ($urandom % 16) == 0;
            ce1_n  = ($urandom % 6) == 0;
            ce2    = ($urandom % 8) != 0;
            ce3_n  = ($urandom % 8) == 0;
            pstb_n = ($urandom % 6) != 0;
            cstb_n = ($urandom % 5) != 0;
            adv_n  = $urandom % 2;
            gw_n   = ($urandom % 8) != 0;
            bwe_n  = $urandom % 2;
            bw_n   = LANES'($urandom);
            oe_n   = ($urandom % 5) == 0;
            burst_lin = $urandom % 2;
            addr   = AW'($urandom);
            dq_i   = DW'($urandom);
            go();
        end
        summary();
    end
endmodule